// File: doc/BRIEF.md
# Byte-Offset Data Alignment Unit

This block lines up a byte stream that does not fall on a doubleword boundary. Two 64-bit operands, taken from consecutive aligned doublewords, are treated as one 128-bit value. The first operand forms the upper half and the second forms the lower half. The block returns the eight bytes that start a given number of bytes into that value. The byte offset is 0 to 7 and comes from the low three bits of a graphics status register. Software keeps that register up to date, so the block takes the three bits directly as an input.

A request is a single cycle with `in_valid` high. One clock edge later the aligned doubleword appears on `out_data`, with `out_valid` high for one cycle. Requests may arrive on back-to-back cycles. Zero offset is a proper case of the selection network: it passes the first operand through, and no shift of the full operand width is ever formed.

Top module: `byte_align_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high in exactly those cycles that follow a clock edge at which `in_valid` was high. Each request yields exactly one result, and results come out in request order.
- R3: When the offset is 0, the result equals `op_hi` unchanged and holds no bits of `op_lo`.
- R4: For any offset n in 0..7, the result equals bits 127:64 of the 128-bit value {`op_hi`, `op_lo`} shifted left by 8·n bits. That is, result bits 63:8n are `op_hi` bits 63-8n:0, and result bits 8n-1:0 are the top n bytes of `op_lo`.
- R5: When the offset is 7, result bits 63:56 are `op_hi` bits 7:0 and result bits 55:0 are `op_lo` bits 63:8.
- R6: In a cycle with `in_valid` low, the operand and offset inputs are ignored. `out_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one request per high cycle |
| op_hi | input | 64 | Earlier doubleword, supplies the upper part of the result |
| op_lo | input | 64 | Later doubleword, supplies the lower part of the result |
| byte_off | input | 3 | Byte offset 0..7, the low three bits of the graphics status register |
| out_valid | output | 1 | High for one cycle when a result is present |
| out_data | output | 64 | Aligned doubleword |

## Verification
Every result is due one cycle after its request: the clock edge that captures `in_valid` also captures the aligned data. The bench drives inputs on the falling edge and pushes the reference value into a queue. It samples one nanosecond after each rising edge, so each popped value is compared against the output of exactly that edge. A valid output with an empty queue, or a queue that is still full at the end, counts as a misordered or lost result. Hold behaviour is checked after idle cycles, during which the inputs change while the strobe stays low.

// File: rtl/byte_align_pkg.sv
package byte_align_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 8;
    localparam int DATA_W = LANE_W * LANES;
    localparam int OFF_W  = $clog2(LANES);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } align_out_t;
endpackage

// File: rtl/align_byte_window.sv
module align_byte_window #(
    parameter int LANE_W = byte_align_pkg::LANE_W,
    parameter int LANES  = byte_align_pkg::LANES,
    localparam int DATA_W = LANE_W * LANES,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [DATA_W-1:0] win_o
);
    logic [2*DATA_W-1:0] joined;
    assign joined = {hi_i, lo_i};

    // Output lane k takes joined lane (k + LANES - off): a per-lane mux,
    // never a shift across the whole operand width.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] pick;
        always_comb begin
            pick = '0;
            for (int s = 0; s < LANES; s++) begin
                if (off_i == OFF_W'(s)) begin
                    pick = joined[(k + LANES - s)*LANE_W +: LANE_W];
                end
            end
        end
        assign win_o[k*LANE_W +: LANE_W] = pick;
    end
endmodule

// File: rtl/align_out_reg.sv
module align_out_reg
    import byte_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] win_i,
    output align_out_t        res_o
);
    align_out_t res_d, res_q;

    always_comb begin
        res_d     = res_q;
        res_d.vld = take_i;
        if (take_i) begin
            res_d.data = win_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_o = res_q;
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit
    import byte_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_hi,
    input  logic [DATA_W-1:0] op_lo,
    input  logic [OFF_W-1:0]  byte_off,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] win;
    align_out_t        res;

    align_byte_window #(
        .LANE_W(LANE_W),
        .LANES (LANES)
    ) u_window (
        .hi_i (op_hi),
        .lo_i (op_lo),
        .off_i(byte_off),
        .win_o(win)
    );

    align_out_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .take_i(in_valid),
        .win_i (win),
        .res_o (res)
    );

    assign out_valid = res.vld;
    assign out_data  = res.data;
endmodule

// File: rtl/byte_align_unit_chk.sv
module byte_align_unit_chk
    import byte_align_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_hi,
    input logic [DATA_W-1:0] op_lo,
    input logic [OFF_W-1:0]  byte_off,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    logic [2*DATA_W-1:0] slid;
    logic [DATA_W-1:0]   model;
    always_comb begin
        slid  = {op_hi, op_lo} << (LANE_W * int'(byte_off));
        model = slid[2*DATA_W-1 -: DATA_W];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_data == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_off == '0) |=> out_data == $past(op_hi));

    // R4
    slice_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_data == $past(model));

    // R5
    top_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_off == OFF_W'(LANES-1)) |=>
        out_data == {$past(op_hi[LANE_W-1:0]), $past(op_lo[DATA_W-1:LANE_W])});

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

bind byte_align_unit byte_align_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_hi    (op_hi),
    .op_lo    (op_lo),
    .byte_off (byte_off),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/byte_align_unit_tb.sv
module byte_align_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_hi = '0;
    logic [63:0] op_lo = '0;
    logic [2:0]  byte_off = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int fails  = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_exp = '0;

    always #2.5 clk = ~clk;

    byte_align_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_hi(op_hi), .op_lo(op_lo), .byte_off(byte_off),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one request per call, reference pushed to the scoreboard.
    task automatic send(input logic [63:0] h, input logic [63:0] l, input logic [2:0] n, input string tag);
        logic [127:0] cat;
        @(negedge clk);
        op_hi = h; op_lo = l; byte_off = n; in_valid = 1'b1;
        cat = {h, l} << (8 * int'(n));
        exp_q.push_back(cat[127:64]);
        tag_q.push_back(tag);
        last_exp = cat[127:64];
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_hi = {$urandom, $urandom}; op_lo = {$urandom, $urandom};
            byte_off = 3'($urandom);
        end
    endtask

    // Monitor: samples 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected valid", out_data, '0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data === e, t, out_data, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] h, l;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 0);
        check(out_data == '0, "R1 data in reset", out_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // R4: every offset on a byte-numbered pattern
        for (int n = 0; n < 8; n++)
            send(64'h0001020304050607, 64'h08090A0B0C0D0E0F, 3'(n), "R4 counting pattern");
        // R3: zero offset, second operand all ones must not leak
        send(64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF, 3'd0, "R3 zero offset");
        send(64'h0, 64'hFFFFFFFFFFFFFFFF, 3'd0, "R3 zero offset, zero hi");
        // R5: top offset
        send(64'hA1A2A3A4A5A6A7A8, 64'hB1B2B3B4B5B6B7B8, 3'd7, "R5 offset 7");
        idle(2);
        // R5: explicit field placement
        h = 64'h1122334455667788; l = 64'h99AABBCCDDEEFF00;
        send(h, l, 3'd7, "R5 offset 7 fields");
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        check(out_data == {h[7:0], l[63:8]}, "R5 explicit slice", out_data, {h[7:0], l[63:8]});

        // R6: inputs change while idle, output holds
        idle(3);
        #1;
        check(out_valid == 1'b0, "R2 idle valid low", 64'(out_valid), 0);
        check(out_data == last_exp, "R6 hold while idle", out_data, last_exp);

        // R4/R2: back-to-back requests with varied data, all offsets
        for (int r = 0; r < 4; r++)
            for (int n = 0; n < 8; n++)
                send({$urandom, $urandom}, {$urandom, $urandom}, 3'(n), "R4 random back-to-back");
        idle(1);
        for (int n = 7; n >= 0; n--)
            send(64'hFFFFFFFFFFFFFFFF, 64'h0, 3'(n), "R4 ones over zeros");
        idle(3);
        #1;
        check(out_data == last_exp, "R6 hold after burst", out_data, last_exp);
        check(exp_q.size() == 0, "R2 every request answered", 64'(exp_q.size()), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule